// File: doc/BRIEF.md
# Frame-Paced ADC Conversion Sequencer

This block sequences an analog-to-digital converter whose requests and results travel over a serial frame link. A separate shifter decodes each incoming frame. When the frame ends it hands this block a one-cycle strobe, the frame's start-request bit and a 3-bit channel address. The sequencer decides whether the request is taken and drives the converter's start pulse and input multiplexer. It times each conversion in whole frames, not in clock cycles. It then shows the result, together with its address and done flags, during the output frame that follows the end of the conversion.

An address whose top bit is set names a pair of sample-and-hold inputs. For a pair the block runs two conversions back to back in a fixed order, with a report frame after each one. A start request that arrives during the last report frame launches the next conversion at once, so one result shifts out while the next conversion is under way. A start request that arrives while the block is busy is dropped. Software can read the busy output to make sure the converter is idle before it asks for any other kind of frame.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is applied and just after it is released, conv_go, busy, done1 and done2 are 0, and out_addr, out_data and mux_sel are all 0.
- R2: A frame_done strobe with frm_start=1 while idle is accepted. In the next cycle conv_go is high for exactly one cycle, busy is 1 and out_addr takes the frame's address.
- R3: A start request is dropped, not queued, when it arrives during a convert phase or during the first report frame of a pair. conv_go stays low and out_addr keeps its value.
- R4: A convert phase spans exactly 4 frame_done strobes after the launching one when slow_pace=0, and 8 when slow_pace=1. slow_pace is sampled at each launch. The report frame begins in the cycle after the last of those strobes.
- R5: conv_data is captured on conv_done during a convert phase. In a report frame, out_data shows that captured value and out_addr shows the current address.
- R6: During a convert phase, out_addr shows the current address and out_data keeps the previously reported result. done1 and done2 are both 0.
- R7: done1 is 1 exactly during the first report frame. done2 is 1 exactly during the second report frame of a pair. The two are never set together.
- R8: For addresses 1xx, the end of the first report frame launches a second conversion with conv_go, using the pair's second mux code. A second paced convert phase and a second report frame follow.
- R9: A start request in the final report frame launches a new conversion at that frame's end. Without one, the block returns to idle.
- R10: The mux_sel codes are: 0 terminal 0, 1 terminal 1, 2 encoder A, 3 encoder A inverted, 4 encoder B, 5 encoder B inverted, 6 direct input A, 7 direct input B. The address decodes as follows. 000 selects 0. 001 selects 1. 010 selects 2 if enc_a_lvl=1, else 3. 011 selects 4 if enc_b_lvl=1, else 5. The pairs are 100 as (2,3), 101 as (2,4), 110 as (4,5) and 111 as (6,7). mux_sel is held between conversions.
- R11: busy is 1 from the cycle after an accepted start through every convert phase and through a pair's first report frame. It is 0 when idle and during the final report frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe at the end of each serial frame |
| frm_start | input | 1 | Start-request bit of the current frame |
| frm_addr | input | 3 | Channel address of the current frame |
| enc_a_lvl | input | 1 | Captured digital level of encoder channel A |
| enc_b_lvl | input | 1 | Captured digital level of encoder channel B |
| slow_pace | input | 1 | 1 selects 8-frame pacing, 0 selects 4-frame pacing |
| conv_done | input | 1 | Converter result-valid pulse |
| conv_data | input | DATA_W | Converter result |
| conv_go | output | 1 | One-cycle converter start pulse |
| mux_sel | output | 3 | Converter input multiplexer code |
| out_addr | output | 3 | Address reported in the output frame |
| out_data | output | DATA_W | Result reported in the output frame |
| done1 | output | 1 | First report frame flag |
| done2 | output | 1 | Second report frame flag of a pair |
| busy | output | 1 | Converter sequence in progress |

## Verification
The bench drives start requests in every frame of a busy phase. A design that queued them, or let them rewrite the address, would show an extra conv_go or a changed out_addr. It also issues requests on the final report frame and on a pair's first report frame. A design that got this wrong would either lose the pipelined launch or wrongly cut a pair short. The bench switches slow_pace between conversions and within a pair. A counter that was latched only once, or was off by one frame, would move the done flags by whole frames. It also checks that out_data shows the old result during conversion and the new one only in report frames.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_SEND  = 3'd2,
    ST_CONV2 = 3'd3,
    ST_SEND2 = 3'd4
  } seq_state_t;

  localparam logic [SEL_W-1:0] SEL_T0  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_T1  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_EA  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_EAN = 3'd3;
  localparam logic [SEL_W-1:0] SEL_EB  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_EBN = 3'd5;
  localparam logic [SEL_W-1:0] SEL_DA  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_DB  = 3'd7;

  // Top address bit marks a sample-and-hold pair.
  function automatic logic is_pair(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  // Mux code used by the first (or only) conversion.
  function automatic logic [SEL_W-1:0] first_sel(logic [ADDR_W-1:0] a,
                                                 logic ea, logic eb);
    case (a)
      3'b000:  return SEL_T0;
      3'b001:  return SEL_T1;
      3'b010:  return ea ? SEL_EA : SEL_EAN;
      3'b011:  return eb ? SEL_EB : SEL_EBN;
      3'b100:  return SEL_EA;
      3'b101:  return SEL_EA;
      3'b110:  return SEL_EB;
      default: return SEL_DA;
    endcase
  endfunction

  // Mux code for the second conversion of a pair.
  function automatic logic [SEL_W-1:0] second_sel(logic [ADDR_W-1:0] a);
    case (a)
      3'b100:  return SEL_EAN;
      3'b101:  return SEL_EB;
      3'b110:  return SEL_EBN;
      3'b111:  return SEL_DB;
      default: return SEL_T0;
    endcase
  endfunction

  // Number of frames spanned by one conversion.
  function automatic int pace_frames(logic slow, int fast_n, int slow_n);
    return slow ? slow_n : fast_n;
  endfunction

endpackage

// File: rtl/adcseq_decode.sv
module adcseq_decode
  import adcseq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              enc_a_lvl,
  input  logic              enc_b_lvl,
  output logic [SEL_W-1:0]  sel_first,
  output logic [SEL_W-1:0]  sel_second,
  output logic              pair
);

  always_comb begin
    sel_first  = first_sel(addr, enc_a_lvl, enc_b_lvl);
    sel_second = second_sel(addr);
    pair       = is_pair(addr);
  end

endmodule

// File: rtl/adcseq_pacer.sv
module adcseq_pacer
  import adcseq_pkg::*;
#(
  parameter int FAST_FRAMES = 4,
  parameter int SLOW_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic slow_pace,
  input  logic active,
  input  logic frame_done,
  output logic window_end
);

  localparam int MAX_FRAMES = (SLOW_FRAMES > FAST_FRAMES) ? SLOW_FRAMES : FAST_FRAMES;
  localparam int CNT_W      = $clog2(MAX_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= CNT_W'(FAST_FRAMES);
    end else if (load) begin
      cnt_q   <= '0;
      limit_q <= CNT_W'(pace_frames(slow_pace, FAST_FRAMES, SLOW_FRAMES));
    end else if (active && frame_done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign window_end = active && frame_done && (cnt_q == limit_q - 1'b1);

  // R4: the frame count never runs past the latched window while converting
  assert_pace_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < limit_q));

endmodule

// File: rtl/adcseq_result.sv
module adcseq_result #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              retire,
  input  logic              showing,
  input  logic [DATA_W-1:0] conv_data,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      if (capture) cur_q  <= conv_data;
      if (retire)  last_q <= cur_q;
    end
  end

  assign out_data = showing ? cur_q : last_q;

  // R5: a finished report frame turns the shown result into the held one
  assert_retire_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (last_q == $past(cur_q)));

  // R6: outside report frames the held result does not change unless retired
  assert_hold_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(last_q));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int FAST_FRAMES = 4,
  parameter int SLOW_FRAMES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              frm_start,
  input  logic [2:0]        frm_addr,
  input  logic              enc_a_lvl,
  input  logic              enc_b_lvl,
  input  logic              slow_pace,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_go,
  output logic [2:0]        mux_sel,
  output logic [2:0]        out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              done1,
  output logic              done2,
  output logic              busy
);

  seq_state_t state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel_q, sec_q;
  logic              pair_q;
  logic              go_q;

  logic [SEL_W-1:0]  dec_first, dec_second;
  logic              dec_pair;

  // named internal events
  logic converting;
  logic final_send;
  logic accept;
  logic launch_pair2;
  logic launch;
  logic window_end;
  logic retire;
  logic showing;

  adcseq_decode u_decode (
    .addr       (frm_addr),
    .enc_a_lvl  (enc_a_lvl),
    .enc_b_lvl  (enc_b_lvl),
    .sel_first  (dec_first),
    .sel_second (dec_second),
    .pair       (dec_pair)
  );

  assign converting   = (state_q == ST_CONV) || (state_q == ST_CONV2);
  assign showing      = (state_q == ST_SEND) || (state_q == ST_SEND2);
  assign final_send   = ((state_q == ST_SEND) && !pair_q) || (state_q == ST_SEND2);
  assign accept       = frame_done && frm_start && ((state_q == ST_IDLE) || final_send);
  assign launch_pair2 = frame_done && (state_q == ST_SEND) && pair_q;
  assign launch       = accept || launch_pair2;
  assign retire       = frame_done && showing;

  adcseq_pacer #(
    .FAST_FRAMES (FAST_FRAMES),
    .SLOW_FRAMES (SLOW_FRAMES)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (launch),
    .slow_pace  (slow_pace),
    .active     (converting),
    .frame_done (frame_done),
    .window_end (window_end)
  );

  adcseq_result #(
    .DATA_W (DATA_W)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (conv_done && converting),
    .retire    (retire),
    .showing   (showing),
    .conv_data (conv_data),
    .out_data  (out_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_CONV;
      ST_CONV:  if (window_end) state_d = ST_SEND;
      ST_SEND:  if (frame_done) state_d = pair_q ? ST_CONV2 : (frm_start ? ST_CONV : ST_IDLE);
      ST_CONV2: if (window_end) state_d = ST_SEND2;
      ST_SEND2: if (frame_done) state_d = frm_start ? ST_CONV : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sel_q   <= '0;
      sec_q   <= '0;
      pair_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= launch;
      if (accept) begin
        addr_q <= frm_addr;
        pair_q <= dec_pair;
        sel_q  <= dec_first;
        sec_q  <= dec_second;
      end else if (launch_pair2) begin
        sel_q <= sec_q;
      end
    end
  end

  assign conv_go  = go_q;
  assign mux_sel  = sel_q;
  assign out_addr = addr_q;
  assign done1    = (state_q == ST_SEND);
  assign done2    = (state_q == ST_SEND2);
  assign busy     = converting || ((state_q == ST_SEND) && pair_q);

  // R2: converter start is a single-cycle pulse
  assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  // R3: a request seen mid-conversion leaves the address untouched
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    converting |=> $stable(out_addr));

  // R4: the first report frame opens only after the pacer closes its window
  assert_send_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done1) |-> $past(window_end));

  // R8: the second report flag only ever belongs to a pair
  assert_second_is_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done2 |-> pair_q);

  // R11: busy is released in the final report frame
  assert_busy_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done2 || (done1 && !pair_q)) |-> !busy);

  // R7: the two report flags never overlap
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done1 && done2));

endmodule

// File: tb/tb_adc_frame_seq.sv
`timescale 1ns/1ps
module tb_adc_frame_seq;

  localparam int DATA_W    = 10;
  localparam int FRAME_CYC = 8;
  localparam int STUB_LAT  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_done = 1'b0;
  logic              frm_start = 1'b0;
  logic [2:0]        frm_addr = '0;
  logic              enc_a_lvl = 1'b0;
  logic              enc_b_lvl = 1'b0;
  logic              slow_pace = 1'b0;
  logic              conv_done = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic              conv_go;
  logic [2:0]        mux_sel;
  logic [2:0]        out_addr;
  logic [DATA_W-1:0] out_data;
  logic              done1, done2, busy;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_frame_seq #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frm_start(frm_start),
    .frm_addr(frm_addr), .enc_a_lvl(enc_a_lvl), .enc_b_lvl(enc_b_lvl),
    .slow_pace(slow_pace), .conv_done(conv_done), .conv_data(conv_data),
    .conv_go(conv_go), .mux_sel(mux_sel), .out_addr(out_addr), .out_data(out_data),
    .done1(done1), .done2(done2), .busy(busy)
  );

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // mode: 0 idle, 1 first convert, 2 first report, 3 second convert, 4 second report
  int          m_mode, m_frames, m_pace;
  logic [2:0]  m_addr, m_sel, m_sec;
  bit          m_pair, m_go;
  logic [DATA_W-1:0] m_cur, m_last;
  string       m_tag;

  function automatic logic [2:0] ref_first(logic [2:0] a, logic ea, logic eb);
    if (a == 3'd0) return 3'd0;
    if (a == 3'd1) return 3'd1;
    if (a == 3'd2) return ea ? 3'd2 : 3'd3;
    if (a == 3'd3) return eb ? 3'd4 : 3'd5;
    if (a == 3'd7) return 3'd6;
    return (a == 3'd6) ? 3'd4 : 3'd2;
  endfunction

  function automatic logic [2:0] ref_second(logic [2:0] a);
    if (a == 3'd4) return 3'd3;
    if (a == 3'd5) return 3'd4;
    if (a == 3'd6) return 3'd5;
    if (a == 3'd7) return 3'd7;
    return 3'd0;
  endfunction

  task model_launch();
    m_addr   = frm_addr;
    m_pair   = frm_addr[2];
    m_sel    = ref_first(frm_addr, enc_a_lvl, enc_b_lvl);
    m_sec    = ref_second(frm_addr);
    m_pace   = slow_pace ? 8 : 4;
    m_frames = 0;
    m_mode   = 1;
    m_go     = 1;
  endtask

  task model_end_send();
    m_last = m_cur;
    m_tag  = "R9";
    if (frm_start) model_launch();
    else m_mode = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_frames = 0; m_pace = 4; m_addr = 0; m_sel = 0; m_sec = 0;
      m_pair = 0; m_go = 0; m_cur = 0; m_last = 0; m_tag = "R2";
    end else begin
      m_go = 0;
      if (conv_done && (m_mode == 1 || m_mode == 3)) m_cur = conv_data;
      if (frame_done) begin
        if (m_mode == 0) begin
          if (frm_start) begin model_launch(); m_tag = "R2"; end
        end else if (m_mode == 1 || m_mode == 3) begin
          if (frm_start) m_tag = "R3";
          m_frames++;
          if (m_frames == m_pace) begin m_mode++; m_tag = "R4"; end
        end else if (m_mode == 2 && m_pair) begin
          m_last = m_cur; m_mode = 3; m_frames = 0;
          m_pace = slow_pace ? 8 : 4; m_sel = m_sec; m_go = 1; m_tag = "R8";
        end else begin
          model_end_send();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_tag, "conv_go", conv_go, m_go);
      chk(m_tag, "done1", done1, m_mode == 2);
      chk("R7", "done2", done2, m_mode == 4);
      chk("R11", "busy", busy, (m_mode == 1) || (m_mode == 3) || (m_mode == 2 && m_pair));
      chk("R6", "out_addr", out_addr, m_addr);
      chk((m_mode == 2 || m_mode == 4) ? "R5" : "R6", "out_data", out_data,
          (m_mode == 2 || m_mode == 4) ? m_cur : m_last);
      chk("R10", "mux_sel", mux_sel, m_sel);
    end
  end

  // ---------------- converter stub ----------------
  int stub_k = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (conv_go) begin
        repeat (STUB_LAT) @(negedge clk);
        stub_k++;
        conv_data = DATA_W'(16'h0A5 + stub_k * 37);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_frame(bit st, logic [2:0] a, bit slow, bit ea, bit eb);
    frm_start = st; frm_addr = a; slow_pace = slow; enc_a_lvl = ea; enc_b_lvl = eb;
    repeat (FRAME_CYC - 1) @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "conv_go", conv_go, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done1", done1, 0);
    chk("R1", "done2", done2, 0);
    chk("R1", "out_data", out_data, 0);
    chk("R1", "out_addr", out_addr, 0);
    chk("R1", "mux_sel", mux_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", busy, 0);

    // single, fast pacing, requests while busy are dropped (R3), idle after (R9)
    run_frame(1, 3'd0, 0, 0, 0);
    for (int i = 0; i < 4; i++) run_frame(1, 3'd1, 0, 0, 0);
    run_frame(0, 3'd0, 0, 0, 0);
    run_frame(0, 3'd0, 0, 0, 0);
    // slow pacing single with pipelined start of a pair in the final report (R9, R8)
    run_frame(1, 3'd1, 1, 0, 0);
    for (int i = 0; i < 8; i++) run_frame(0, 3'd0, 0, 0, 0);
    run_frame(1, 3'd4, 0, 1, 0);
    for (int i = 0; i < 4; i++) run_frame(1, 3'd2, 1, 0, 0);
    run_frame(1, 3'd3, 1, 0, 0);   // first report of pair: request dropped
    for (int i = 0; i < 8; i++) run_frame(0, 3'd0, 0, 0, 0);
    run_frame(0, 3'd0, 0, 0, 0);
    // every address with both encoder levels (R10)
    for (int a = 0; a < 8; a++) begin
      for (int e = 0; e < 4; e++) begin
        run_frame(1, 3'(a), e[0], e[0], e[1]);
        for (int f = 0; f < 22; f++) run_frame(0, 3'd0, f[1], 0, 0);
      end
    end
    // pseudo-random traffic
    for (int i = 0; i < 400; i++)
      run_frame(($urandom % 3) == 0, 3'($urandom), ($urandom % 4) == 0,
                1'($urandom), 1'($urandom));
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule